// File: doc/BRIEF.md
# Rank Filter Instruction Sequencer

This block drives a bit-serial rank-order filter core. Every cycle it issues a two-part instruction. The data-field part moves samples: it sets the rank, loads a sample at an address, copies the sample window into the working store, or retires a result. The computing-field part reads one bit-slice or writes a polarizing mask. The core itself is not part of this block. After a start pulse, the sequencer issues a single rank-setting instruction and then repeats a fixed per-sample schedule until reset.

Two modes are supported.

- **Plain rank mode.** The schedule has 2·BITS−1 steps and overlaps consecutive samples. The next sample is loaded during the slice read for the least significant bit. The copy happens during the read for the most significant bit. The previous result is retired during the first polarizing write.
- **Recursive median mode.** The schedule has 2·BITS+2 steps. It first loads a fresh external sample with the input select low. It then loads the core's previous output with the input select high, and this load goes to the address half a window ahead.

In both modes the load address advances by one after each iteration and wraps at the window size. A stall input freezes the sequence. While stall is high, both fields show no-ops.

Top module: `rankInstrSeq`

## Requirements
- R1: After reset and until a start pulse, both opcodes are no-op (0), the mask is 0 and the input select is 0.
- R2: A start pulse seen while idle causes exactly one SET data-field opcode (1), issued in the cycle after the pulse, with `rankOut` holding the rank sampled with the pulse. SET never appears again until reset.
- R3: In plain rank mode (`modeIn`=0) the schedule repeats every 2·BITS−1 steps, as follows:
  - Step 0 is LOAD (2) paired with READ (1) of bit 0.
  - Step 1 is COPY (3) paired with READ of bit BITS−1.
  - Step 2 is DONE (4) paired with WRITE (2) below bit BITS−1.
  - The remaining steps alternate READ of bit k and WRITE below bit k, for k from BITS−2 down to 1.
- R4: The load address starts at 0 and increments after the last step of each iteration, wrapping from WIN−1 to 0.
- R5: In recursive median mode (`modeIn`=1) the schedule repeats every 2·BITS+2 steps, as follows:
  - Step 0 is LOAD and step 1 is DONE, both with the input select at 0.
  - Step 2 is LOAD with the input select at 1.
  - Step 3 is COPY with READ of bit BITS−1.
  - The remaining steps alternate WRITE below bit k+1 and READ of bit k, for k from BITS−2 down to 0, with the input select at 1.
  - During steps 0 to 2 the computing-field opcode is no-op (0).
- R6: The step-2 load of the recursive schedule uses address (i + WIN/2) mod WIN, where i is the current load address.
- R7: While `stall` is 1, both opcodes are no-op. When `stall` returns to 0, the schedule resumes at the step where it stopped, with no step skipped or repeated.
- R8: A start pulse while the sequence is running has no effect on the instruction stream.
- R9: A READ mask is one-hot at the bit being read. A WRITE mask has ones in every position below the given bit and zeros from that bit upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when idle |
| modeIn | input | 1 | 0 plain rank, 1 recursive median; sampled with start |
| rankIn | input | RANK_W | Rank value; sampled with start |
| stall | input | 1 | Freezes the sequence and forces no-ops |
| dfOp | output | 3 | Data-field opcode: 0 no-op, 1 SET, 2 LOAD, 3 COPY, 4 DONE |
| addr | output | ADDR_W | Load address (valid with LOAD) |
| cfOp | output | 2 | Computing-field opcode: 0 no-op, 1 READ, 2 WRITE |
| mask | output | BITS | Read or write mask |
| inSel | output | 1 | Core input select: 0 external sample, 1 previous output |
| rankOut | output | RANK_W | Rank carried by SET |

## Verification
The plain rank mode is run for more than a full address cycle, so that the wrap from WIN−1 to 0 and the overlapped load, copy and retire steps all appear. The recursive mode is run for the same length, which separates the fresh-sample load from the half-window load and shows the input-select pattern. Stalls are inserted at an iteration start, in the middle of an iteration and during the final write, so that a skipped or repeated step shows up as a mismatch in the stream. A start pulse issued mid-run must leave the stream unchanged.

// File: rtl/rankSeqPkg.sv
package rankSeqPkg;
  typedef enum logic [2:0] {
    DF_NOP  = 3'd0,
    DF_SET  = 3'd1,
    DF_LOAD = 3'd2,
    DF_COPY = 3'd3,
    DF_DONE = 3'd4
  } dfOp_e;

  typedef enum logic [1:0] {
    CF_NOP   = 2'd0,
    CF_READ  = 2'd1,
    CF_WRITE = 2'd2
  } cfOp_e;

  typedef struct packed {
    logic bumpAddr;
    logic useHalf;
    logic readMask;
    logic writeMask;
  } seqStrobe_t;
endpackage

// File: rtl/rankSeqCtrl.sv
module rankSeqCtrl
  import rankSeqPkg::*;
#(
  parameter int BITS   = 8,
  parameter int RANK_W = 4,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              modeIn,
  input  logic [RANK_W-1:0] rankIn,
  input  logic              stall,
  output logic [2:0]        dfOp,
  output logic [1:0]        cfOp,
  output logic              inSel,
  output logic [RANK_W-1:0] rankOut,
  output seqStrobe_t        strobe,
  output logic [BIT_W-1:0]  bitIdx
);
  localparam int NR_LEN = 2 * BITS - 1;
  localparam int RM_LEN = 2 * BITS + 2;
  localparam int STEP_W = $clog2(RM_LEN);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN} seqState_e;

  seqState_e         state;
  logic              recMode;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] lastStep;

  assign lastStep = recMode ? STEP_W'(RM_LEN - 1) : STEP_W'(NR_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      recMode <= 1'b0;
      step    <= '0;
      rankOut <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_SETUP;
          recMode <= modeIn;
          rankOut <= rankIn;
        end
        S_SETUP: if (!stall) begin
          state <= S_RUN;
          step  <= '0;
        end
        default: if (!stall) step <= (step == lastStep) ? '0 : step + 1'b1;
      endcase
    end
  end

  always_comb begin
    int s;
    int k;
    dfOp   = DF_NOP;
    cfOp   = CF_NOP;
    strobe = '0;
    bitIdx = '0;
    inSel  = (state == S_RUN) && recMode && (step >= STEP_W'(2));
    s      = int'(step);
    k      = 0;
    if (state == S_SETUP && !stall) begin
      dfOp = DF_SET;
    end else if (state == S_RUN && !stall) begin
      if (!recMode) begin
        if (s == 0) begin
          dfOp = DF_LOAD;
          cfOp = CF_READ;
        end else if (s[0]) begin
          cfOp = CF_READ;
          k    = BITS - 1 - (s - 1) / 2;
          if (s == 1) dfOp = DF_COPY;
        end else begin
          cfOp = CF_WRITE;
          k    = BITS - s / 2;
          if (s == 2) dfOp = DF_DONE;
        end
      end else begin
        if (s == 0) dfOp = DF_LOAD;
        else if (s == 1) dfOp = DF_DONE;
        else if (s == 2) begin
          dfOp = DF_LOAD;
          strobe.useHalf = 1'b1;
        end else if (s[0]) begin
          cfOp = CF_READ;
          k    = BITS - 1 - (s - 3) / 2;
          if (s == 3) dfOp = DF_COPY;
        end else begin
          cfOp = CF_WRITE;
          k    = BITS + 1 - s / 2;
        end
      end
      strobe.readMask  = (cfOp == CF_READ);
      strobe.writeMask = (cfOp == CF_WRITE);
      strobe.bumpAddr  = (step == lastStep);
      bitIdx           = BIT_W'(k);
    end
  end

  // R1: nothing is issued before the start pulse
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (dfOp == DF_NOP && cfOp == CF_NOP && !inSel));
  // R2: the rank is set only once, before the loop
  a_r2_set_once: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) |-> (dfOp != DF_SET));
  // R7: a stall freezes the step position
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN && stall) |=> $stable(step));
  // R8: the mode cannot change once running
  a_r8_mode_locked: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) |=> $stable(recMode));
endmodule

// File: rtl/rankSeqPath.sv
module rankSeqPath
  import rankSeqPkg::*;
#(
  parameter int WIN    = 9,
  parameter int BITS   = 8,
  parameter int ADDR_W = 4,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [BIT_W-1:0]  bitIdx,
  output logic [ADDR_W-1:0] addr,
  output logic [BITS-1:0]   mask
);
  localparam int HALF = WIN / 2;

  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W:0]   halfSum;

  always_ff @(posedge clk) begin
    if (rst) addrCnt <= '0;
    else if (strobe.bumpAddr)
      addrCnt <= (addrCnt == ADDR_W'(WIN - 1)) ? '0 : addrCnt + 1'b1;
  end

  always_comb begin
    halfSum = {1'b0, addrCnt} + (ADDR_W + 1)'(HALF);
    if (halfSum >= (ADDR_W + 1)'(WIN)) halfSum = halfSum - (ADDR_W + 1)'(WIN);
    addr = strobe.useHalf ? halfSum[ADDR_W-1:0] : addrCnt;
  end

  always_comb begin
    mask = '0;
    if (strobe.readMask) mask = BITS'(1) << bitIdx;
    else if (strobe.writeMask) mask = (BITS'(1) << bitIdx) - BITS'(1);
  end

  // R4: the address counter stays inside the window
  a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
    addrCnt < ADDR_W'(WIN));
  // R4: the address moves only at an iteration end
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.bumpAddr |=> $stable(addrCnt));
  // R6: the half-window address is also inside the window
  a_r6_half_range: assert property (@(posedge clk) disable iff (rst)
    strobe.useHalf |-> addr < ADDR_W'(WIN));
  // R9: a read selects exactly one bit
  a_r9_read_onehot: assert property (@(posedge clk) disable iff (rst)
    strobe.readMask |-> $onehot(mask));
endmodule

// File: rtl/rankInstrSeq.sv
module rankInstrSeq
  import rankSeqPkg::*;
#(
  parameter int WIN    = 9,
  parameter int BITS   = 8,
  parameter int RANK_W = $clog2(WIN + 1),
  parameter int ADDR_W = $clog2(WIN),
  parameter int BIT_W  = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              modeIn,
  input  logic [RANK_W-1:0] rankIn,
  input  logic              stall,
  output logic [2:0]        dfOp,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        cfOp,
  output logic [BITS-1:0]   mask,
  output logic              inSel,
  output logic [RANK_W-1:0] rankOut
);
  seqStrobe_t       strobe;
  logic [BIT_W-1:0] bitIdx;

  rankSeqCtrl #(.BITS(BITS), .RANK_W(RANK_W), .BIT_W(BIT_W)) ctrl (
    .clk(clk), .rst(rst), .start(start), .modeIn(modeIn), .rankIn(rankIn),
    .stall(stall), .dfOp(dfOp), .cfOp(cfOp), .inSel(inSel),
    .rankOut(rankOut), .strobe(strobe), .bitIdx(bitIdx)
  );

  rankSeqPath #(.WIN(WIN), .BITS(BITS), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) path (
    .clk(clk), .rst(rst), .strobe(strobe), .bitIdx(bitIdx),
    .addr(addr), .mask(mask)
  );
endmodule

// File: tb/rankInstrSeq_test.sv
module rankInstrSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 9;
  localparam int BITS = 8;
  localparam int ITERS = 11;

  logic clk = 0, rst = 1, start = 0, modeIn = 0, stall = 0;
  logic [3:0] rankIn = 0;
  logic [2:0] dfOp;
  logic [3:0] addr;
  logic [1:0] cfOp;
  logic [7:0] mask;
  logic inSel;
  logic [3:0] rankOut;

  int total = 0, bad = 0;
  bit live = 0;

  typedef struct {
    int df; int cf; int ad; int mk; int sel; int rk; string tag;
  } item_t;
  item_t expQ[$];
  item_t cur;

  rankInstrSeq uut (.clk(clk), .rst(rst), .start(start), .modeIn(modeIn),
    .rankIn(rankIn), .stall(stall), .dfOp(dfOp), .addr(addr), .cfOp(cfOp),
    .mask(mask), .inSel(inSel), .rankOut(rankOut));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int df, int cf, int ad, int mk, int sel, int rk, string tag);
    item_t it;
    it.df = df; it.cf = cf; it.ad = ad; it.mk = mk; it.sel = sel; it.rk = rk; it.tag = tag;
    expQ.push_back(it);
  endtask

  // R3/R4: plain rank stream, built slice by slice
  task automatic buildPlain(int rk);
    push(1, 0, 0, 0, 0, rk, "R2");
    for (int it = 0; it < ITERS; it++) begin
      push(2, 1, it % WIN, 1, 0, 0, "R3_R4");
      push(3, 1, 0, 1 << (BITS - 1), 0, 0, "R3");
      push(4, 2, 0, (1 << (BITS - 1)) - 1, 0, 0, "R3_R9");
      for (int b = BITS - 2; b >= 1; b--) begin
        push(0, 1, 0, 1 << b, 0, 0, "R3_R9");
        push(0, 2, 0, (1 << b) - 1, 0, 0, "R3_R9");
      end
    end
  endtask

  // R5/R6: recursive median stream
  task automatic buildRec(int rk);
    push(1, 0, 0, 0, 0, rk, "R2");
    for (int it = 0; it < ITERS; it++) begin
      push(2, 0, it % WIN, 0, 0, 0, "R5_R4");
      push(4, 0, 0, 0, 0, 0, "R5");
      push(2, 0, (it % WIN + WIN / 2) % WIN, 0, 1, 0, "R6");
      push(3, 1, 0, 1 << (BITS - 1), 1, 0, "R5");
      for (int b = BITS - 2; b >= 0; b--) begin
        push(0, 2, 0, (1 << (b + 1)) - 1, 1, 0, "R5_R9");
        push(0, 1, 0, 1 << b, 1, 0, "R5_R9");
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live && !rst) begin
      if (stall) begin
        check(dfOp == 0 && cfOp == 0, "R7 nop", {dfOp, 2'b0, cfOp}, 0);
      end else if (expQ.size() == 0) begin
        live = 0;
      end else begin
        cur = expQ.pop_front();
        check(int'(dfOp) == cur.df, cur.tag, dfOp, cur.df);
        check(int'(cfOp) == cur.cf, cur.tag, cfOp, cur.cf);
        check(int'(mask) == cur.mk, cur.tag, mask, cur.mk);
        check(int'(inSel) == cur.sel, cur.tag, inSel, cur.sel);
        if (cur.df == 2) check(int'(addr) == cur.ad, cur.tag, addr, cur.ad);
        if (cur.df == 1) check(int'(rankOut) == cur.rk, cur.tag, rankOut, cur.rk);
      end
    end
  end

  task automatic doReset();
    rst = 1; start = 0; stall = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    repeat (4) begin
      @(negedge clk);
      check(dfOp == 0 && cfOp == 0 && mask == 0 && inSel == 0, "R1", {dfOp, cfOp}, 0);
    end
  endtask

  task automatic kick(bit md, int rk);
    @(posedge clk); #1 start = 1; modeIn = md; rankIn = 4'(rk);
    @(posedge clk); #1 start = 0; live = 1;
  endtask

  task automatic stallFor(int n);
    @(posedge clk); #1 stall = 1;
    repeat (n) @(posedge clk);
    #1 stall = 0;
  endtask

  task automatic runStimulus();
    repeat (14) @(posedge clk);
    stallFor(3);
    repeat (20) @(posedge clk);
    stallFor(1);
    @(posedge clk); #1 start = 1; modeIn = ~modeIn; rankIn = 4'd7;  // R8
    @(posedge clk); #1 start = 0;
    repeat (37) @(posedge clk);
    stallFor(2);
    wait (expQ.size() == 0);
    repeat (3) @(posedge clk);
    live = 0;
  endtask

  initial begin
    doReset();
    buildPlain(3);
    kick(0, 3);
    runStimulus();
    doReset();
    buildRec(5);
    kick(1, 5);
    runStimulus();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog expired, remaining=%0d expected=0", expQ.size());
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule